// File: doc/BRIEF.md
# Pin Ownership GPIO Controller

This block arbitrates control of a bank of digital pads between their peripherals and a set of software-visible global registers. Each pad has an ownership bit. While that bit is clear, the peripheral's output level, drive request and open-drain request pass through to the pad. While it is set, the global registers set the pin's direction, drive style and level.

Drive style can be push-pull or open-drain. Open-drain is emulated at the pad enable: the pad is pulled low for a 0 and released for a 1. Every pad input passes through a two-stage synchronizer. The synchronized level goes back to the peripheral and to a read-only register on the bus.

A small word-addressed register bus gives access to the ownership, direction, drive-style and level registers, and to the synchronized read-back. Writes complete in one clock cycle. Read data is a combinational decode of the address.

Top module: `pad_owner_top`

## Requirements
- R1: While reset is active, and directly after it, the ownership, direction, drive-style and level registers all read 0, and every pad follows its peripheral.
- R2: For a pin whose ownership bit is 0, the pad follows its peripheral: pad enable equals the peripheral drive request, and pad output equals the peripheral level, unless the peripheral requests open-drain (see R5).
- R3: For a pin whose ownership bit is 1 and whose direction bit is 0, the pad enable is 0, so the pin is an input.
- R4: For a pin whose ownership bit is 1, whose direction bit is 1 and whose drive-style bit is 0, the pad enable is 1 and the pad output equals the pin's level-register bit.
- R5: In open-drain drive, chosen by the drive-style bit under global ownership or by the peripheral's open-drain request otherwise, a driven level of 0 gives pad enable 1 with pad output 0. A level of 1 gives pad enable 0, and pad output stays 0.
- R6: A pad input change appears on `perIn` and in the read-back register after exactly two rising clock edges, for every pin whatever its direction.
- R7: Register map by word address: 0 ownership, 1 direction, 2 drive style (1 = open-drain), 3 level, 4 synchronized read-back. Pin n sits at bit n, and bits 31 to 30 always read 0.
- R8: Writes to address 4 and to the unused addresses 5 to 7 change no register. Unused addresses read as 0.
- R9: A write to the ownership register reaches the pads right after the clock edge that captures it, and not before. Pins whose bits did not change keep their pad values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe, captured on the rising edge |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| perOut | input | 30 | Peripheral output level per pin |
| perOe | input | 30 | Peripheral drive request per pin |
| perOd | input | 30 | Peripheral open-drain request per pin |
| perIn | output | 30 | Synchronized pad level to peripherals |
| padIn | input | 30 | Raw pad input level |
| padOut | output | 30 | Pad output level |
| padOe | output | 30 | Pad output enable |

## Verification
The hardest situation to reach from the ports is a bank of mixed pins. In it, some pins are globally owned in push-pull, some are globally owned in open-drain, and the rest stay with peripherals that request open-drain. An ownership write then changes only part of that bank. The stimulus builds this state one register at a time, with distinct peripheral patterns on the pins that stay with their peripherals. Around each ownership write it samples every pad output both before and after the capturing edge, so a pin that changes too early, or that should not change at all, is caught.

// File: rtl/pad_owner_pkg.sv
package pad_owner_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_OWN  = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_ODR  = 3'd2,
    SEL_LVL  = 3'd3,
    SEL_SYNC = 3'd4
  } regSel_e;

  typedef struct packed {
    logic    wrOwn;
    logic    wrDir;
    logic    wrOdr;
    logic    wrLvl;
    logic    rdValid;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/pad_owner_ctrl.sv
module pad_owner_ctrl
  import pad_owner_pkg::*;
(
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe         = '0;
    strobe.rdSel   = SEL_OWN;
    strobe.rdValid = 1'b0;
    case (busAddr)
      SEL_OWN:  begin strobe.wrOwn = busWrite; strobe.rdSel = SEL_OWN;  strobe.rdValid = 1'b1; end
      SEL_DIR:  begin strobe.wrDir = busWrite; strobe.rdSel = SEL_DIR;  strobe.rdValid = 1'b1; end
      SEL_ODR:  begin strobe.wrOdr = busWrite; strobe.rdSel = SEL_ODR;  strobe.rdValid = 1'b1; end
      SEL_LVL:  begin strobe.wrLvl = busWrite; strobe.rdSel = SEL_LVL;  strobe.rdValid = 1'b1; end
      SEL_SYNC: begin strobe.rdSel = SEL_SYNC; strobe.rdValid = 1'b1; end
      default:  begin strobe.rdValid = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pad_owner_path.sv
module pad_owner_path
  import pad_owner_pkg::*;
#(
  parameter int NUM_PINS = 30,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] perOut,
  input  logic [NUM_PINS-1:0] perOe,
  input  logic [NUM_PINS-1:0] perOd,
  output logic [NUM_PINS-1:0] perIn,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] ownBits,
  output logic [NUM_PINS-1:0] dirBits,
  output logic [NUM_PINS-1:0] odrBits,
  output logic [NUM_PINS-1:0] lvlBits
);
  localparam int FILL_W = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] wrSlice;
  logic [NUM_PINS-1:0] syncA;
  logic [NUM_PINS-1:0] syncB;
  logic [NUM_PINS-1:0] rdSlice;

  assign wrSlice = busWdata[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownBits <= '0;
      dirBits <= '0;
      odrBits <= '0;
      lvlBits <= '0;
    end else begin
      if (strobe.wrOwn) ownBits <= wrSlice;
      if (strobe.wrDir) dirBits <= wrSlice;
      if (strobe.wrOdr) odrBits <= wrSlice;
      if (strobe.wrLvl) lvlBits <= wrSlice;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign perIn = syncB;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic effDrive;
    logic effOpen;
    logic effLevel;
    always_comb begin
      effDrive = ownBits[p] ? dirBits[p] : perOe[p];
      effOpen  = ownBits[p] ? odrBits[p] : perOd[p];
      effLevel = ownBits[p] ? lvlBits[p] : perOut[p];
      if (effOpen) begin
        padOut[p] = 1'b0;
        padOe[p]  = effDrive & ~effLevel;
      end else begin
        padOut[p] = effLevel;
        padOe[p]  = effDrive;
      end
    end
  end

  always_comb begin
    case (strobe.rdSel)
      SEL_OWN:  rdSlice = ownBits;
      SEL_DIR:  rdSlice = dirBits;
      SEL_ODR:  rdSlice = odrBits;
      SEL_LVL:  rdSlice = lvlBits;
      SEL_SYNC: rdSlice = syncB;
      default:  rdSlice = '0;
    endcase
    busRdata = strobe.rdValid ? {{FILL_W{1'b0}}, rdSlice} : '0;
  end
endmodule

// File: rtl/pad_owner_top.sv
module pad_owner_top
  import pad_owner_pkg::*;
#(
  parameter int NUM_PINS = 30,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrite,
  input  logic [2:0]          busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] perOut,
  input  logic [NUM_PINS-1:0] perOe,
  input  logic [NUM_PINS-1:0] perOd,
  output logic [NUM_PINS-1:0] perIn,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe
);
  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] ownBits;
  logic [NUM_PINS-1:0] dirBits;
  logic [NUM_PINS-1:0] odrBits;
  logic [NUM_PINS-1:0] lvlBits;

  pad_owner_ctrl u_ctrl (
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  pad_owner_path #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .perOut   (perOut),
    .perOe    (perOe),
    .perOd    (perOd),
    .perIn    (perIn),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .ownBits  (ownBits),
    .dirBits  (dirBits),
    .odrBits  (odrBits),
    .lvlBits  (lvlBits)
  );
endmodule

// File: rtl/pad_owner_chk.sv
module pad_owner_chk #(
  parameter int NUM_PINS = 30,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrite,
  input logic [2:0]          busAddr,
  input logic [DATA_W-1:0]   busWdata,
  input logic [DATA_W-1:0]   busRdata,
  input logic [NUM_PINS-1:0] perOut,
  input logic [NUM_PINS-1:0] perOe,
  input logic [NUM_PINS-1:0] perOd,
  input logic [NUM_PINS-1:0] perIn,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] ownBits,
  input logic [NUM_PINS-1:0] dirBits,
  input logic [NUM_PINS-1:0] odrBits,
  input logic [NUM_PINS-1:0] lvlBits
);
  logic [1:0] sinceRst;
  logic [NUM_PINS-1:0] openMask;
  logic [NUM_PINS-1:0] ppMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  assign openMask = (ownBits & odrBits) | (~ownBits & perOd);
  assign ppMask   = ownBits & dirBits & ~odrBits;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |-> (ownBits == '0 && dirBits == '0 && odrBits == '0 && lvlBits == '0)); // R1

  AST_PERIPH_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe ^ perOe) | (padOut ^ perOut)) & ~ownBits & ~perOd) == '0); // R2

  AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (ownBits & ~dirBits & padOe) == '0); // R3

  AST_PUSH_PULL_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & ppMask) == ppMask) && (((padOut ^ lvlBits) & ppMask) == '0)); // R4

  AST_OPEN_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (openMask & padOut) == '0); // R5

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (perIn == $past(padIn, 2))); // R6

  AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:NUM_PINS] == '0); // R7

  AST_SYNC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr >= 3'd4) |=> ($stable(ownBits) && $stable(dirBits) && $stable(odrBits) && $stable(lvlBits))); // R8

  AST_OWN_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 3'd0) |=> (ownBits == $past(busWdata[NUM_PINS-1:0]))); // R9
endmodule

bind pad_owner_top pad_owner_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/pad_owner_top_bench.sv
module pad_owner_top_bench;
  localparam int NP = 30;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrite = 1'b0;
  logic [2:0]    busAddr = 3'd0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NP-1:0] perOut = '0;
  logic [NP-1:0] perOe = '0;
  logic [NP-1:0] perOd = '0;
  logic [NP-1:0] perIn;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut;
  logic [NP-1:0] padOe;

  always #2 clk = ~clk;

  pad_owner_top u_pad_owner_top (.*);

  typedef struct {
    int          kind;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  sampleEv;
  int    nChk = 0;
  int    nBad = 0;
  bit    done = 0;

  logic [NP-1:0] shOwn = '0;
  logic [NP-1:0] shDir = '0;
  logic [NP-1:0] shOdr = '0;
  logic [NP-1:0] shLvl = '0;

  function automatic logic [NP-1:0] mdlOe();
    logic [NP-1:0] drv, opn, lvl;
    drv = (shOwn & shDir) | (~shOwn & perOe);
    opn = (shOwn & shOdr) | (~shOwn & perOd);
    lvl = (shOwn & shLvl) | (~shOwn & perOut);
    return (drv & ~opn) | (drv & opn & ~lvl);
  endfunction

  function automatic logic [NP-1:0] mdlOut();
    logic [NP-1:0] opn, lvl;
    opn = (shOwn & shOdr) | (~shOwn & perOd);
    lvl = (shOwn & shLvl) | (~shOwn & perOut);
    return lvl & ~opn;
  endfunction

  function automatic logic [31:0] actual(int kind);
    case (kind)
      0:       return busRdata;
      1:       return {2'b00, padOut};
      2:       return {2'b00, padOe};
      default: return {2'b00, perIn};
    endcase
  endfunction

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = actual(it.kind);
        nChk++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          nBad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic push(int kind, logic [31:0] mask, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.mask = mask; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->sampleEv;
  endtask

  task automatic chkPads(string tag);
    push(1, 32'h3FFF_FFFF, {2'b00, mdlOut()}, tag);
    push(2, 32'h3FFF_FFFF, {2'b00, mdlOe()}, tag);
  endtask

  task automatic rdChk(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    push(0, 32'hFFFF_FFFF, exp, tag);
  endtask

  // write, checking pads before the capturing edge (old state) and after it
  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    #1;
    chkPads({tag, " before edge R9"});
    @(negedge clk);
    busWrite = 1'b0;
    case (a)
      3'd0: shOwn = d[NP-1:0];
      3'd1: shDir = d[NP-1:0];
      3'd2: shOdr = d[NP-1:0];
      3'd3: shLvl = d[NP-1:0];
      default: ;
    endcase
    #1;
    chkPads({tag, " after edge R9"});
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    perOut = 30'h2AAA_5555; perOe = 30'h0F0F_F0F0; perOd = '0;
    #1;
    push(2, 32'h3FFF_FFFF, {2'b00, perOe}, "R1 pad follows peripheral in reset");
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: all registers clear after reset
    rdChk(3'd0, 32'h0, "R1 own reg");
    rdChk(3'd1, 32'h0, "R1 dir reg");
    rdChk(3'd2, 32'h0, "R1 odr reg");
    rdChk(3'd3, 32'h0, "R1 lvl reg");
    #1; chkPads("R1 pads after reset");

    // R2: peripheral passthrough, several patterns
    @(negedge clk); perOut = 30'h1234_5678; perOe = 30'h3FFF_0000; #1; chkPads("R2 pattern a");
    @(negedge clk); perOut = 30'h3FFF_FFFF; perOe = 30'h0000_FFFF; #1; chkPads("R2 pattern b");
    // R5: peripheral open-drain request
    @(negedge clk); perOd = 30'h0F0F_0F0F; perOe = 30'h3FFF_FFFF; perOut = 30'h0033_3300; #1;
    chkPads("R5 peripheral open-drain");

    // R3 and R9: take low byte to global control, starts as input
    wr(3'd0, 32'h0000_00FF, "R3 own low byte");
    // R4: push-pull outputs on pins 3..0
    wr(3'd3, 32'h0000_0005, "R4 level");
    wr(3'd1, 32'h0000_000F, "R4 direction");
    // R5: open-drain on pins 1..0 (pin0 level 1 released, pin1 level 0 driven low)
    wr(3'd2, 32'h0000_0003, "R5 global open-drain");
    // R9: partial ownership change, other pins unchanged
    wr(3'd0, 32'h0000_0F0F, "R9 ownership change");
    @(negedge clk); perOut = 30'h3C3C_3C3C; perOd = 30'h0000_F000; #1;
    chkPads("R2 mixed bank peripheral pins");

    // R7: register map read-back, upper bits zero
    wr(3'd3, 32'hFFFF_FFFF, "R7 level all ones");
    rdChk(3'd3, 32'h3FFF_FFFF, "R7 level read bits 31..30 zero");
    rdChk(3'd0, 32'h0000_0F0F, "R7 own read");
    rdChk(3'd1, 32'h0000_000F, "R7 dir read");
    rdChk(3'd2, 32'h0000_0003, "R7 odr read");

    // R6: synchronizer latency
    @(negedge clk); padIn = 30'h2468_ACE1; #1;
    push(3, 32'h3FFF_FFFF, 32'h0, "R6 zero edges");
    @(negedge clk); #1;
    push(3, 32'h3FFF_FFFF, 32'h0, "R6 one edge");
    @(negedge clk); #1;
    push(3, 32'h3FFF_FFFF, {2'b00, 30'h2468_ACE1}, "R6 two edges");
    rdChk(3'd4, {2'b00, 30'h2468_ACE1}, "R6 read-back sync");

    // R8: writes to read-back and unused addresses ignored
    wr(3'd4, 32'h0000_0000, "R8 write sync reg");
    rdChk(3'd4, {2'b00, 30'h2468_ACE1}, "R8 sync reg unchanged");
    wr(3'd5, 32'hFFFF_FFFF, "R8 write unused");
    rdChk(3'd5, 32'h0, "R8 unused reads 0");
    rdChk(3'd7, 32'h0, "R8 unused 7 reads 0");
    rdChk(3'd0, 32'h0000_0F0F, "R8 own unchanged");
    rdChk(3'd3, 32'h3FFF_FFFF, "R8 lvl unchanged");

    // R9: release everything back to peripherals
    wr(3'd0, 32'h0000_0000, "R9 release all");

    #1;
    ->sampleEv;
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule